// File: doc/BRIEF.md
# Banked Working-Register File

This block holds the working registers of a small 8-bit processor: four banks of eight byte registers, plus a 16-bit stack pointer, the program status word, two segment registers and a mapping-control byte. A processor-side port reads and writes by register index. A byte index touches one register of the active bank. A pair index touches two neighbouring bytes as one 16-bit value. Two bits of the status word pick the active bank. The bank change applies from the cycle after the status-word write.

The whole 32-byte bank area can also be reached through a separate byte-wide window port. This port addresses every bank directly, whatever bank is active. When both ports write the same byte in the same clock cycle, the processor port wins. A condition evaluator reports whether a branch condition holds. It uses the zero and carry flags of the status word, or for the T and F conditions a supplied test value.

Top module: `bankreg_file`

## Requirements
- R1: After reset every one of the 32 bank bytes reads 0x11. The status word reads 0x06, the extra-segment register 0x0F, and the code-segment, mapping-control and stack-pointer registers 0x00.
- R2: Register indices 1 to 8 name the byte registers X, A, C, B, E, D, L and H. Within a bank they occupy byte offsets 0 to 7 in that order. A byte write stores wr_data[7:0], and a byte read returns the value zero-extended.
- R3: The active bank n is formed as {psw[5], psw[3]}. It lives at window addresses (3 − n)·8 to (3 − n)·8 + 7, so bank 0 is the top eight bytes.
- R4: Indices 9 to 12 name the pairs AX, BC, DE and HL. The first-named register is bits 15:8 and the second is bits 7:0, for both reads and writes.
- R5: Index 13 is the stack pointer. A write stores the value with bit 0 cleared. In the cycle after a write of an odd value, sp_odd is 1; otherwise it is 0.
- R6: cond_true follows cond_sel: 0 T (cond_val ≠ 0), 1 F (cond_val = 0), 2 C (carry psw[0] = 1), 3 NC, 4 H (zero psw[6] and carry both 0), 5 NH, 6 Z (zero = 1), 7 NZ.
- R7: Reading index 0 returns 0 with no error. Indices 18 to 31 are illegal, and so is a write to index 0. Either case raises idx_err in the same cycle, an illegal read returns 0, and an illegal write changes no register.
- R8: The window port reads (combinationally) and writes (on the clock edge) any of the 32 bank bytes at win_addr, independent of the active bank.
- R9: When the processor port and the window port write the same byte in one cycle, the processor value is stored. Writes to different bytes in the same cycle both take effect.
- R10: A status-word write changes the active bank only from the next cycle. Reads in the writing cycle still use the old bank.
- R11: Indices 14 to 17 write and read the status word, code segment, extra segment and mapping-control byte from bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Processor-port write strobe |
| wr_idx | input | 5 | Register index to write |
| wr_data | input | 16 | Write value (bits 7:0 for byte targets) |
| rd_idx | input | 5 | Register index to read |
| rd_data | output | 16 | Read value, combinational |
| idx_err | output | 1 | Illegal read or write index this cycle |
| sp_odd | output | 1 | Previous cycle wrote an odd stack-pointer value |
| win_we | input | 1 | Window write strobe |
| win_addr | input | 5 | Window byte address |
| win_wdata | input | 8 | Window write byte |
| win_rdata | output | 8 | Window read byte, combinational |
| cond_sel | input | 3 | Branch condition code |
| cond_val | input | 16 | Value tested by T and F |
| cond_true | output | 1 | Condition result |

## Verification
Two activities can meet in one cycle: a processor-port write and a window-port write. The bench drives both in the same cycle, first at the same byte, then at a different byte, and once at the upper half of a pair write. Afterwards it reads every affected window address. The shared byte must hold the processor value, and the untouched target must hold the window value. A second overlap is a status-word write with a read in the same cycle, which is checked against the old bank.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

   localparam int OFF_W = 3;

   localparam int IX_NONE = 0;
   localparam int IX_X    = 1;
   localparam int IX_H    = 8;
   localparam int IX_AX   = 9;
   localparam int IX_HL   = 12;
   localparam int IX_SP   = 13;
   localparam int IX_PSW  = 14;
   localparam int IX_CS   = 15;
   localparam int IX_ES   = 16;
   localparam int IX_PMC  = 17;

   localparam int PSW_CY   = 0;
   localparam int PSW_RBS0 = 3;
   localparam int PSW_RBS1 = 5;
   localparam int PSW_Z    = 6;

   localparam logic [2:0] CND_T  = 3'd0;
   localparam logic [2:0] CND_F  = 3'd1;
   localparam logic [2:0] CND_C  = 3'd2;
   localparam logic [2:0] CND_NC = 3'd3;
   localparam logic [2:0] CND_H  = 3'd4;
   localparam logic [2:0] CND_NH = 3'd5;
   localparam logic [2:0] CND_Z  = 3'd6;
   localparam logic [2:0] CND_NZ = 3'd7;

   typedef enum logic [3:0] {
      K_NONE, K_BYTE, K_PAIR, K_SP, K_PSW, K_CS, K_ES, K_PMC, K_BAD
   } kind_e;

endpackage

// File: rtl/bankreg_idx_dec.sv
module bankreg_idx_dec
   import bankreg_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] idx,
   output kind_e            kind,
   output logic [OFF_W-1:0] off_lo,
   output logic [OFF_W-1:0] off_hi
);

   logic [IDX_W-1:0] rel;

   always_comb begin
      kind   = K_BAD;
      off_lo = '0;
      off_hi = '0;
      rel    = '0;
      if (idx == IDX_W'(IX_NONE)) begin
         kind = K_NONE;
      end else if (idx <= IDX_W'(IX_H)) begin
         kind   = K_BYTE;
         rel    = idx - IDX_W'(IX_X);
         off_lo = rel[OFF_W-1:0];
         off_hi = rel[OFF_W-1:0];
      end else if (idx <= IDX_W'(IX_HL)) begin
         kind   = K_PAIR;
         rel    = idx - IDX_W'(IX_AX);
         off_lo = {rel[OFF_W-2:0], 1'b0};
         off_hi = {rel[OFF_W-2:0], 1'b1};
      end else begin
         case (idx)
            IDX_W'(IX_SP):  kind = K_SP;
            IDX_W'(IX_PSW): kind = K_PSW;
            IDX_W'(IX_CS):  kind = K_CS;
            IDX_W'(IX_ES):  kind = K_ES;
            IDX_W'(IX_PMC): kind = K_PMC;
            default:        kind = K_BAD;
         endcase
      end
   end

endmodule

// File: rtl/bankreg_array.sv
module bankreg_array #(
   parameter int          DEPTH     = 32,
   parameter int          DW        = 8,
   parameter logic [7:0]  RESET_VAL = 8'h11,
   localparam int         AW        = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_we_lo,
   input  logic [AW-1:0]             cpu_addr_lo,
   input  logic [DW-1:0]             cpu_din_lo,
   input  logic                      cpu_we_hi,
   input  logic [AW-1:0]             cpu_addr_hi,
   input  logic [DW-1:0]             cpu_din_hi,
   input  logic                      win_we,
   input  logic [AW-1:0]             win_addr,
   input  logic [DW-1:0]             win_din,
   output logic [DEPTH-1:0][DW-1:0]  mem_q
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= DW'(RESET_VAL);
         else if (cpu_we_lo && cpu_addr_lo == AW'(g))
            q <= cpu_din_lo;
         else if (cpu_we_hi && cpu_addr_hi == AW'(g))
            q <= cpu_din_hi;
         else if (win_we && win_addr == AW'(g))
            q <= win_din;
      end
      assign mem_q[g] = q;
   end

   // R9: processor port beats the window on a shared byte
   a_r9_cpu_wins_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we_lo && win_we && win_addr == cpu_addr_lo)
      |=> mem_q[$past(cpu_addr_lo)] == $past(cpu_din_lo));

   a_r9_cpu_wins_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we_hi && win_we && win_addr == cpu_addr_hi)
      |=> mem_q[$past(cpu_addr_hi)] == $past(cpu_din_hi));

   // R8: window write lands when no processor write targets that byte
   a_r8_win_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (win_we && !(cpu_we_lo && cpu_addr_lo == win_addr)
              && !(cpu_we_hi && cpu_addr_hi == win_addr))
      |=> mem_q[$past(win_addr)] == $past(win_din));

endmodule

// File: rtl/bankreg_cond.sv
module bankreg_cond
   import bankreg_pkg::*;
#(
   parameter int VAL_W = 16
) (
   input  logic [2:0]       sel,
   input  logic             zf,
   input  logic             cf,
   input  logic [VAL_W-1:0] val,
   output logic             hit
);

   always_comb begin
      case (sel)
         CND_T:   hit = |val;
         CND_F:   hit = ~|val;
         CND_C:   hit = cf;
         CND_NC:  hit = ~cf;
         CND_H:   hit = ~(zf | cf);
         CND_NH:  hit = zf | cf;
         CND_Z:   hit = zf;
         default: hit = ~zf;
      endcase
   end

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
   import bankreg_pkg::*;
#(
   parameter int          NUM_BANKS = 4,
   parameter int          REGS      = 8,
   parameter int          DW        = 8,
   parameter int          IDX_W     = 5,
   parameter logic [7:0]  BYTE_RST  = 8'h11,
   parameter logic [7:0]  PSW_RST   = 8'h06,
   parameter logic [7:0]  ES_RST    = 8'h0F,
   parameter logic [7:0]  CS_RST    = 8'h00,
   parameter logic [7:0]  PMC_RST   = 8'h00,
   localparam int         DEPTH     = NUM_BANKS * REGS,
   localparam int         AW        = $clog2(DEPTH),
   localparam int         WW        = 2 * DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WW-1:0]    wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [WW-1:0]    rd_data,
   output logic             idx_err,
   output logic             sp_odd,
   input  logic             win_we,
   input  logic [AW-1:0]    win_addr,
   input  logic [DW-1:0]    win_wdata,
   output logic [DW-1:0]    win_rdata,
   input  logic [2:0]       cond_sel,
   input  logic [WW-1:0]    cond_val,
   output logic             cond_true
);

   if (NUM_BANKS != 4) begin : g_chk_banks
      $error("bankreg_file: two status bits select exactly four banks");
   end
   if (REGS != (1 << OFF_W)) begin : g_chk_regs
      $error("bankreg_file: each bank must hold eight byte registers");
   end
   if (DW != 8) begin : g_chk_dw
      $error("bankreg_file: status word layout needs byte-wide registers");
   end

   kind_e            wr_kind, rd_kind;
   logic [OFF_W-1:0] wr_lo, wr_hi, rd_lo, rd_hi;
   logic [1:0]       bank;
   logic [AW-OFF_W-1:0] base;
   logic [DEPTH-1:0][DW-1:0] mem_q;
   logic [DW-1:0]    psw_q, cs_q, es_q, pmc_q, sp_lo_q, sp_hi_q;
   logic             sp_odd_q;

   bankreg_idx_dec #(.IDX_W(IDX_W)) u_wdec (
      .idx(wr_idx), .kind(wr_kind), .off_lo(wr_lo), .off_hi(wr_hi));
   bankreg_idx_dec #(.IDX_W(IDX_W)) u_rdec (
      .idx(rd_idx), .kind(rd_kind), .off_lo(rd_lo), .off_hi(rd_hi));

   // Bank n sits at (3 - n) * 8: the inverted bank number is the base.
   assign bank = {psw_q[PSW_RBS1], psw_q[PSW_RBS0]};
   assign base = ~bank;

   logic          cpu_we_lo, cpu_we_hi;
   logic [AW-1:0] wa_lo, wa_hi, ra_lo, ra_hi;

   assign cpu_we_lo = wr_en && (wr_kind == K_BYTE || wr_kind == K_PAIR);
   assign cpu_we_hi = wr_en && (wr_kind == K_PAIR);
   assign wa_lo     = {base, wr_lo};
   assign wa_hi     = {base, wr_hi};
   assign ra_lo     = {base, rd_lo};
   assign ra_hi     = {base, rd_hi};

   bankreg_array #(.DEPTH(DEPTH), .DW(DW), .RESET_VAL(BYTE_RST)) u_arr (
      .clk(clk), .rst_n(rst_n),
      .cpu_we_lo(cpu_we_lo), .cpu_addr_lo(wa_lo), .cpu_din_lo(wr_data[DW-1:0]),
      .cpu_we_hi(cpu_we_hi), .cpu_addr_hi(wa_hi), .cpu_din_hi(wr_data[WW-1:DW]),
      .win_we(win_we), .win_addr(win_addr), .win_din(win_wdata),
      .mem_q(mem_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psw_q    <= PSW_RST;
         cs_q     <= CS_RST;
         es_q     <= ES_RST;
         pmc_q    <= PMC_RST;
         sp_lo_q  <= '0;
         sp_hi_q  <= '0;
         sp_odd_q <= 1'b0;
      end else begin
         sp_odd_q <= wr_en && wr_kind == K_SP && wr_data[0];
         if (wr_en) begin
            case (wr_kind)
               K_PSW: psw_q <= wr_data[DW-1:0];
               K_CS:  cs_q  <= wr_data[DW-1:0];
               K_ES:  es_q  <= wr_data[DW-1:0];
               K_PMC: pmc_q <= wr_data[DW-1:0];
               K_SP: begin
                  sp_lo_q <= {wr_data[DW-1:1], 1'b0};
                  sp_hi_q <= wr_data[WW-1:DW];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (rd_kind)
         K_BYTE:  rd_data = {{DW{1'b0}}, mem_q[ra_lo]};
         K_PAIR:  rd_data = {mem_q[ra_hi], mem_q[ra_lo]};
         K_SP:    rd_data = {sp_hi_q, sp_lo_q};
         K_PSW:   rd_data = {{DW{1'b0}}, psw_q};
         K_CS:    rd_data = {{DW{1'b0}}, cs_q};
         K_ES:    rd_data = {{DW{1'b0}}, es_q};
         K_PMC:   rd_data = {{DW{1'b0}}, pmc_q};
         default: rd_data = '0;
      endcase
   end

   assign idx_err   = (wr_en && (wr_kind == K_BAD || wr_kind == K_NONE))
                    || (rd_kind == K_BAD);
   assign sp_odd    = sp_odd_q;
   assign win_rdata = mem_q[win_addr];

   bankreg_cond #(.VAL_W(WW)) u_cond (
      .sel(cond_sel), .zf(psw_q[PSW_Z]), .cf(psw_q[PSW_CY]),
      .val(cond_val), .hit(cond_true));

   // R5: stored stack pointer is always even
   a_r5_sp_even: assert property (@(posedge clk) disable iff (!rst_n)
      sp_lo_q[0] == 1'b0);

   // R5: odd write raises the flag next cycle
   a_r5_odd_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_kind == K_SP && wr_data[0]) |=> sp_odd);

   // R7: an illegal write leaves every register untouched
   a_r7_bad_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_kind == K_BAD || wr_kind == K_NONE) && !win_we)
      |=> ($stable(mem_q) && $stable(psw_q) && $stable({sp_hi_q, sp_lo_q})
           && $stable(cs_q) && $stable(es_q) && $stable(pmc_q)));

   // R4: a pair write puts the upper half in the first-named register
   a_r4_pair_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we_hi && !win_we) |=> mem_q[$past(wa_hi)] == $past(wr_data[WW-1:DW]));

endmodule

// File: tb/sim_bankreg_file.sv
`timescale 1ns/1ps
module sim_bankreg_file;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic [4:0]  rd_idx = '0;
   logic [15:0] rd_data;
   logic        idx_err, sp_odd;
   logic        win_we = 1'b0;
   logic [4:0]  win_addr = '0;
   logic [7:0]  win_wdata = '0;
   logic [7:0]  win_rdata;
   logic [2:0]  cond_sel = '0;
   logic [15:0] cond_val = '0;
   logic        cond_true;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   bankreg_file u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .idx_err(idx_err), .sp_odd(sp_odd),
      .win_we(win_we), .win_addr(win_addr), .win_wdata(win_wdata),
      .win_rdata(win_rdata), .cond_sel(cond_sel), .cond_val(cond_val),
      .cond_true(cond_true));

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic cpu_wr(logic [4:0] idx, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic win_wr(logic [4:0] a, logic [7:0] d);
      @(negedge clk);
      win_we = 1'b1; win_addr = a; win_wdata = d;
      @(negedge clk);
      win_we = 1'b0;
   endtask

   task automatic rd(logic [4:0] idx, output logic [15:0] d);
      rd_idx = idx; #1; d = rd_data;
   endtask

   task automatic wrd(logic [4:0] a, output logic [7:0] d);
      win_addr = a; #1; d = win_rdata;
   endtask

   task automatic t_reset;
      logic [15:0] v; logic [7:0] b;
      for (int i = 0; i < 32; i++) begin wrd(5'(i), b); chk("R1 byte", 16'(b), 16'h11); end
      rd(14, v); chk("R1 psw", v, 16'h06);
      rd(16, v); chk("R1 es", v, 16'h0F);
      rd(15, v); chk("R1 cs", v, 16'h00);
      rd(17, v); chk("R1 pmc", v, 16'h00);
      rd(13, v); chk("R1 sp", v, 16'h0000);
      chk("R1 sp_odd", 16'(sp_odd), 16'h0);
   endtask

   task automatic t_bytes; // R2 in bank 0 (window 24..31)
      logic [15:0] v; logic [7:0] b;
      for (int i = 0; i < 8; i++) cpu_wr(5'(1 + i), 16'hFF00 | 16'(8'hA0 + i));
      for (int i = 0; i < 8; i++) begin
         wrd(5'(24 + i), b); chk("R2 window offset", 16'(b), 16'(8'hA0 + i));
         rd(5'(1 + i), v);   chk("R2 byte read", v, 16'(8'hA0 + i));
      end
   endtask

   task automatic t_pairs;
      logic [15:0] v;
      cpu_wr(10, 16'h1234);
      rd(4, v);  chk("R4 B high", v, 16'h12);
      rd(3, v);  chk("R4 C low", v, 16'h34);
      rd(10, v); chk("R4 BC read", v, 16'h1234);
      rd(9, v);  chk("R4 AX read", v, 16'hA1A0);
   endtask

   task automatic t_bank_timing; // R10
      logic [15:0] v; logic [7:0] b;
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 14; wr_data = 16'h000E; rd_idx = 1; #1;
      chk("R10 old bank in write cycle", rd_data, 16'h00A0);
      @(negedge clk);
      wr_idx = 1; wr_data = 16'h0077; #1;
      chk("R10 new bank next cycle", rd_data, 16'h0011);
      @(negedge clk);
      wr_en = 1'b0;
      wrd(16, b); chk("R10 write to bank1", 16'(b), 16'h77);
      wrd(24, b); chk("R10 bank0 kept", 16'(b), 16'hA0);
      rd(14, v);  chk("R11 psw", v, 16'h0E);
   endtask

   task automatic t_banks; // R3
      logic [7:0] b;
      cpu_wr(14, 16'h0026); cpu_wr(1, 16'h0066);
      wrd(8, b); chk("R3 bank2 at 8", 16'(b), 16'h66);
      cpu_wr(14, 16'h002E); cpu_wr(8, 16'h00E7);
      wrd(7, b); chk("R3 bank3 H at 7", 16'(b), 16'hE7);
      cpu_wr(14, 16'h0006);
   endtask

   task automatic t_window; // R8
      logic [15:0] v; logic [7:0] b;
      win_wr(3, 8'h42);
      rd(4, v);  chk("R8 bank0 B untouched", v, 16'h12);
      wrd(3, b); chk("R8 window read", 16'(b), 16'h42);
      cpu_wr(14, 16'h002E);
      rd(4, v);  chk("R8 bank3 B via cpu", v, 16'h42);
      cpu_wr(14, 16'h0006);
   endtask

   task automatic t_conflict; // R9
      logic [7:0] b;
      @(negedge clk);
      wr_en = 1; wr_idx = 1; wr_data = 16'h00C1; win_we = 1; win_addr = 24; win_wdata = 8'h3C;
      @(negedge clk);
      wr_idx = 12; wr_data = 16'hBEEF; win_addr = 5; win_wdata = 8'h5A;
      @(negedge clk);
      wr_idx = 11; wr_data = 16'h1357; win_addr = 29; win_wdata = 8'h99;
      @(negedge clk);
      wr_en = 0; win_we = 0;
      wrd(24, b); chk("R9 same byte cpu wins", 16'(b), 16'hC1);
      wrd(30, b); chk("R9 L written", 16'(b), 16'hEF);
      wrd(31, b); chk("R9 H written", 16'(b), 16'hBE);
      wrd(5, b);  chk("R9 other byte window", 16'(b), 16'h5A);
      wrd(29, b); chk("R9 pair high cpu wins", 16'(b), 16'h13);
      wrd(28, b); chk("R9 pair low", 16'(b), 16'h57);
   endtask

   task automatic t_sp; // R5
      logic [15:0] v;
      cpu_wr(13, 16'h1235);
      chk("R5 odd flag", 16'(sp_odd), 16'h1);
      rd(13, v); chk("R5 truncated", v, 16'h1234);
      @(negedge clk);
      chk("R5 flag is a pulse", 16'(sp_odd), 16'h0);
      cpu_wr(13, 16'h2000);
      chk("R5 even no flag", 16'(sp_odd), 16'h0);
      rd(13, v); chk("R5 even stored", v, 16'h2000);
   endtask

   task automatic t_cond; // R6
      logic e;
      for (int f = 0; f < 4; f++) begin
         logic z, c;
         z = f[1]; c = f[0];
         cpu_wr(14, 16'h0006 | (16'(z) << 6) | 16'(c));
         for (int s = 2; s < 8; s++) begin
            case (s)
               2: e = c;  3: e = !c;  4: e = !(z | c);
               5: e = z | c;  6: e = z;  default: e = !z;
            endcase
            cond_sel = 3'(s); #1;
            chk("R6 flag cond", 16'(cond_true), 16'(e));
         end
      end
      cond_sel = 0; cond_val = 16'h0100; #1; chk("R6 T nonzero", 16'(cond_true), 16'h1);
      cond_sel = 1; #1;                     chk("R6 F nonzero", 16'(cond_true), 16'h0);
      cond_val = 0; #1;                     chk("R6 F zero", 16'(cond_true), 16'h1);
      cond_sel = 0; #1;                     chk("R6 T zero", 16'(cond_true), 16'h0);
      cpu_wr(14, 16'h0006);
   endtask

   task automatic t_sfr; // R11
      logic [15:0] v;
      cpu_wr(15, 16'h000A); cpu_wr(16, 16'h0003); cpu_wr(17, 16'h0001);
      rd(15, v); chk("R11 cs", v, 16'h0A);
      rd(16, v); chk("R11 es", v, 16'h03);
      rd(17, v); chk("R11 pmc", v, 16'h01);
   endtask

   task automatic t_illegal; // R7
      logic [7:0] snap [32];
      logic [15:0] v; logic [7:0] b;
      for (int i = 0; i < 32; i++) wrd(5'(i), snap[i]);
      @(negedge clk);
      rd_idx = 1; wr_en = 1; wr_idx = 20; wr_data = 16'hFFFF; #1;
      chk("R7 bad write err", 16'(idx_err), 16'h1);
      @(negedge clk);
      wr_idx = 0; #1;
      chk("R7 write to none err", 16'(idx_err), 16'h1);
      @(negedge clk);
      wr_en = 0; #1;
      for (int i = 0; i < 32; i++) begin
         wrd(5'(i), b); chk("R7 bytes unchanged", 16'(b), 16'(snap[i]));
      end
      rd(14, v); chk("R7 psw unchanged", v, 16'h06);
      rd(13, v); chk("R7 sp unchanged", v, 16'h2000);
      rd(0, v);  chk("R7 none reads 0", v, 16'h0);
      chk("R7 none no err", 16'(idx_err), 16'h0);
      rd(25, v); chk("R7 bad read 0", v, 16'h0);
      chk("R7 bad read err", 16'(idx_err), 16'h1);
      rd_idx = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bytes();
      t_pairs();
      t_bank_timing();
      t_banks();
      t_window();
      t_conflict();
      t_sp();
      t_cond();
      t_sfr();
      t_illegal();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog all requirements act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule